// File: doc/BRIEF.md
# Dual-Work Flash Partition Controller

This block sits beside the array of a four-plane flash device and answers two questions for every host access. First, which physical plane and which logical partition does the word address fall in? Second, may a read be served from the array, or must it be sent to the status register because the partition is busy? The planes are fixed quarters of the address space. The partitions are virtual groupings of adjacent planes, chosen by a small configuration register. That register is written through a simple write port. After reset it takes a default that depends on whether the device carries its small parameter blocks at the top or at the bottom of the array.

The command logic reports the busy state of program/erase, full-chip erase and one-time-program operations, together with the address of the running operation. From these the controller flags reads that must return status. It also guards the device's two state-changing requests. A request to start a program or erase in a partition that is already working is rejected, and so is a configuration change while anything is running. Each rejection raises a one-clock error pulse. The plan and partition outputs are combinational from the host address. The configuration and the error flag are registered.

Top module: `flash_partition_ctrl`

## Requirements
- R1: The plane index covers quarters of the array. With `size_64`=0 the plane is `addr[20:19]` and `addr[21]` has no effect (quarter size 080000h). With `size_64`=1 the plane is `addr[21:20]` (quarter size 100000h).
- R2: Configuration bit n (n = 0, 1, 2) set means a partition boundary lies between plane n and plane n+1. The partition index of a plane is the number of set configuration bits below it, so partitions are numbered in increasing plane order.
- R3: Configuration value 3'b111 gives four partitions, with the partition index equal to the plane index.
- R4: While `rst_n` is low at a clock edge, the configuration is loaded with 3'b100 when `param_top`=1 (planes 0 to 2 together, plane 3 alone) and with 3'b001 when `param_top`=0 (plane 0 alone, planes 1 to 3 together). The error flag is cleared.
- R5: With no operation active, `rd_status` is 0 for every address. While only a program/erase is active, a read whose partition differs from the partition of `busy_addr` has `rd_status`=0.
- R6: While a program/erase is active, a read in the same partition as `busy_addr` has `rd_status`=1.
- R7: While a full-chip erase or an OTP program is active, `rd_status`=1 for every address.
- R8: A configuration write (`cfg_wr`=1) with no operation of any kind active takes effect at the next clock edge. It does not raise `err`.
- R9: A configuration write while any operation is active leaves the configuration unchanged. `err` is 1 in the following cycle only.
- R10: `op_req`=1 at `addr` while a program/erase is active in the same partition raises `err` for the following cycle only. A request in another partition does not raise `err`.
- R11: `op_req`=1 while a full-chip erase or an OTP program is active raises `err` for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Host word address (read target or start address of a request) |
| size_64 | input | 1 | 1 selects the large (64M) array, 0 the small (32M) array |
| param_top | input | 1 | Strap: 1 means parameter blocks are at the top plane |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 3 | Partition boundary bits to write |
| pe_busy | input | 1 | A program or erase is running |
| chip_erase_busy | input | 1 | A full-chip erase is running |
| otp_busy | input | 1 | An OTP program is running |
| busy_addr | input | ADDR_W | Address of the running program or erase |
| op_req | input | 1 | Request to start a program or erase at `addr` |
| plane_idx | output | 2 | Physical plane of `addr` |
| part_idx | output | 2 | Logical partition of `addr` |
| rd_status | output | 1 | 1: read returns status; 0: read returns array data |
| err | output | 1 | One-clock pulse for a rejected request or configuration write |

## Verification
The bench goes after the plane edges on both array sizes, including the top address bit on the small array. A decoder that did not mask that bit would report plane 3 for an address in plane 1. It writes all eight configuration values and checks every plane. An off-by-one in the boundary counting would merge or split the wrong planes, and the mistake would show most clearly in the four-partition and single-partition cases. For dual work it reads from the busy partition, from a neighbour sharing a merged partition and from an unrelated partition. A design that compared planes instead of partitions would hand array data from a busy merged partition. It also blocks configuration writes and repeated requests. A design that let the write through, or held the error flag longer than one cycle, would show a changed mapping or a second high `err` sample.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int NUM_PLANES = 4;
    localparam int PLANE_W    = $clog2(NUM_PLANES);
    localparam int CFG_W      = NUM_PLANES - 1;

    typedef logic [CFG_W-1:0]   cfg_t;
    typedef logic [PLANE_W-1:0] plane_t;

    typedef struct packed {
        cfg_t cfg;
        logic err;
    } ctrl_state_t;

    // Boundary set after reset, picked by the parameter strap.
    function automatic cfg_t reset_cfg(input logic param_top);
        cfg_t v;
        v = '0;
        if (param_top) v[CFG_W-1] = 1'b1;   // last plane stands alone
        else           v[0]       = 1'b1;   // first plane stands alone
        return v;
    endfunction

endpackage

// File: rtl/plane_decode.sv
module plane_decode
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_64,
    output plane_t            plane
);
    localparam logic [ADDR_W-1:0] SPAN_BIG   = ADDR_W'(1) << (ADDR_W - PLANE_W);
    localparam logic [ADDR_W-1:0] SPAN_SMALL = ADDR_W'(1) << (ADDR_W - PLANE_W - 1);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] window;

    always_comb begin
        span   = size_64 ? SPAN_BIG : SPAN_SMALL;
        // Small array: the top address bit lies outside the array.
        window = size_64 ? addr : {1'b0, addr[ADDR_W-2:0]};
        plane  = '0;
        for (int k = 1; k < NUM_PLANES; k++) begin
            if (window >= (ADDR_W'(k) * span)) plane = plane_t'(k);
        end
    end
endmodule

// File: rtl/partition_map.sv
module partition_map
    import fpc_pkg::*;
(
    input  cfg_t   cfg,
    input  plane_t plane,
    output plane_t part
);
    always_comb begin
        part = '0;
        for (int n = 0; n < CFG_W; n++) begin
            if ((n < int'(plane)) && cfg[n]) part = part + plane_t'(1);
        end
    end
endmodule

// File: rtl/access_guard.sv
module access_guard
    import fpc_pkg::*;
(
    input  plane_t host_part,
    input  plane_t busy_part,
    input  logic   pe_busy,
    input  logic   chip_erase_busy,
    input  logic   otp_busy,
    input  logic   op_req,
    input  logic   cfg_wr,
    output logic   rd_status,
    output logic   cfg_accept,
    output logic   reject
);
    logic exclusive;
    logic any_busy;
    logic same_part;

    always_comb begin
        exclusive  = chip_erase_busy | otp_busy;
        any_busy   = exclusive | pe_busy;
        same_part  = pe_busy & (host_part == busy_part);
        rd_status  = exclusive | same_part;
        cfg_accept = cfg_wr & ~any_busy;
        reject     = (cfg_wr & any_busy) | (op_req & (exclusive | same_part));
    end
endmodule

// File: rtl/flash_partition_ctrl.sv
module flash_partition_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_64,
    input  logic              param_top,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_data,
    input  logic              pe_busy,
    input  logic              chip_erase_busy,
    input  logic              otp_busy,
    input  logic [ADDR_W-1:0] busy_addr,
    input  logic              op_req,
    output logic [1:0]        plane_idx,
    output logic [1:0]        part_idx,
    output logic              rd_status,
    output logic              err
);
    localparam int LOOKUPS = 2;   // host address and busy address

    ctrl_state_t state_d, state_q;

    logic [ADDR_W-1:0] lk_addr  [LOOKUPS];
    plane_t            lk_plane [LOOKUPS];
    plane_t            lk_part  [LOOKUPS];

    logic cfg_accept;
    logic reject;

    assign lk_addr[0] = addr;
    assign lk_addr[1] = busy_addr;

    for (genvar i = 0; i < LOOKUPS; i++) begin : g_lookup
        plane_decode #(.ADDR_W(ADDR_W)) u_plane (
            .addr    (lk_addr[i]),
            .size_64 (size_64),
            .plane   (lk_plane[i])
        );
        partition_map u_part (
            .cfg   (state_q.cfg),
            .plane (lk_plane[i]),
            .part  (lk_part[i])
        );
    end

    access_guard u_guard (
        .host_part       (lk_part[0]),
        .busy_part       (lk_part[1]),
        .pe_busy         (pe_busy),
        .chip_erase_busy (chip_erase_busy),
        .otp_busy        (otp_busy),
        .op_req          (op_req),
        .cfg_wr          (cfg_wr),
        .rd_status       (rd_status),
        .cfg_accept      (cfg_accept),
        .reject          (reject)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = reject;
        if (cfg_accept) state_d.cfg = cfg_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cfg <= reset_cfg(param_top);
            state_q.err <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign plane_idx = lk_plane[0];
    assign part_idx  = lk_part[0];
    assign err       = state_q.err;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       param_top,
    input logic       cfg_wr,
    input logic [2:0] cfg_data,
    input logic       pe_busy,
    input logic       chip_erase_busy,
    input logic       otp_busy,
    input logic       op_req,
    input logic [1:0] plane_idx,
    input logic [1:0] part_idx,
    input logic       rd_status,
    input logic       err,
    input logic [2:0] cfg_q
);
    logic any_busy;
    assign any_busy = pe_busy | chip_erase_busy | otp_busy;

    assert_reset_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_q == ($past(param_top) ? 3'b100 : 3'b001)));

    assert_part_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        part_idx <= plane_idx);

    assert_four_part_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == 3'b111) |-> (part_idx == plane_idx));

    assert_idle_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_busy |-> !rd_status);

    assert_exclusive_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_busy || otp_busy) |-> rd_status);

    assert_cfg_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !any_busy) |=> (cfg_q == $past(cfg_data)));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && any_busy) |=> ((cfg_q == $past(cfg_q)) && err));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(op_req || cfg_wr));

    assert_exclusive_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && (chip_erase_busy || otp_busy)) |=> err);
endmodule

bind flash_partition_ctrl fpc_checker u_fpc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .param_top       (param_top),
    .cfg_wr          (cfg_wr),
    .cfg_data        (cfg_data),
    .pe_busy         (pe_busy),
    .chip_erase_busy (chip_erase_busy),
    .otp_busy        (otp_busy),
    .op_req          (op_req),
    .plane_idx       (plane_idx),
    .part_idx        (part_idx),
    .rd_status       (rd_status),
    .err             (err),
    .cfg_q           (state_q.cfg)
);

// File: tb/test_flash_partition_ctrl.sv
`timescale 1ns/1ps
module test_flash_partition_ctrl;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          size_64 = 1'b1;
    logic          param_top = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_data = '0;
    logic          pe_busy = 1'b0;
    logic          chip_erase_busy = 1'b0;
    logic          otp_busy = 1'b0;
    logic [AW-1:0] busy_addr = '0;
    logic          op_req = 1'b0;
    logic [1:0]    plane_idx, part_idx;
    logic          rd_status, err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_partition_ctrl #(.ADDR_W(AW)) i_flash_partition_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size_64(size_64),
        .param_top(param_top), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .pe_busy(pe_busy), .chip_erase_busy(chip_erase_busy),
        .otp_busy(otp_busy), .busy_addr(busy_addr), .op_req(op_req),
        .plane_idx(plane_idx), .part_idx(part_idx),
        .rd_status(rd_status), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Partition of a plane from the requirement: set boundary bits below it.
    function automatic int exp_part(input logic [2:0] c, input int p);
        int r = 0;
        for (int n = 0; n < 3; n++) if (n < p && c[n]) r++;
        return r;
    endfunction

    function automatic logic [AW-1:0] base(input bit big, input int p);
        return big ? AW'(p) * AW'(24'h100000) : AW'(p) * AW'(24'h080000);
    endfunction

    task automatic look(input logic [AW-1:0] a);
        addr = a;
        #1;
    endtask

    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset;
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            rst_n = 1'b0; param_top = (s == 0);
            @(negedge clk);
            @(negedge clk);
            rst_n = 1'b1;
            for (int p = 0; p < 4; p++) begin
                look(base(1'b1, p));
                check("R4 reset partition", part_idx,
                      exp_part((s == 0) ? 3'b100 : 3'b001, p));
            end
            check("R4 reset err", err, 0);
        end
    endtask

    task automatic t_plane;
        @(negedge clk);
        size_64 = 1'b0;
        look(22'h080000); check("R1 small plane1 low edge", plane_idx, 1);
        look(22'h07FFFF); check("R1 small plane0 high edge", plane_idx, 0);
        look(22'h17FFFF); check("R1 small plane2 high edge", plane_idx, 2);
        look(22'h1FFFFF); check("R1 small plane3 top", plane_idx, 3);
        look(22'h280000); check("R1 small top bit ignored", plane_idx, 1);
        size_64 = 1'b1;
        look(22'h0FFFFF); check("R1 big plane0 high edge", plane_idx, 0);
        look(22'h100000); check("R1 big plane1 low edge", plane_idx, 1);
        look(22'h2FFFFF); check("R1 big plane2 high edge", plane_idx, 2);
        look(22'h3FFFFF); check("R1 big plane3 top", plane_idx, 3);
    endtask

    task automatic t_cfg_all;
        for (int v = 0; v < 8; v++) begin
            write_cfg(3'(v));
            check("R8 no err on accepted write", err, 0);
            for (int p = 0; p < 4; p++) begin
                look(base(1'b1, p) + 22'h00123);
                check((v == 7) ? "R3 four partitions" : "R2 partition map",
                      part_idx, exp_part(3'(v), p));
            end
        end
    endtask

    task automatic t_dual;
        write_cfg(3'b010);              // partitions {0,1} and {2,3}
        @(negedge clk);
        pe_busy = 1'b1; busy_addr = base(1'b1, 2) + 22'h40;
        look(base(1'b1, 2) + 22'h900); check("R6 busy plane read", rd_status, 1);
        look(base(1'b1, 3));           check("R6 merged neighbour read", rd_status, 1);
        look(base(1'b1, 1) + 22'h5);   check("R5 other partition read", rd_status, 0);
        look(base(1'b1, 0));           check("R5 other partition plane0", rd_status, 0);
        pe_busy = 1'b0;
        look(base(1'b1, 2));           check("R5 idle read", rd_status, 0);
    endtask

    task automatic t_cfg_blocked;
        write_cfg(3'b001);
        @(negedge clk);
        pe_busy = 1'b1; busy_addr = base(1'b1, 0);
        cfg_wr = 1'b1; cfg_data = 3'b111;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R9 err after blocked write", err, 1);
        @(negedge clk);
        check("R9 err one cycle", err, 0);
        pe_busy = 1'b0;
        look(base(1'b1, 3)); check("R9 mapping unchanged", part_idx, 1);
        @(negedge clk);
        otp_busy = 1'b1; cfg_wr = 1'b1; cfg_data = 3'b000;
        @(negedge clk);
        cfg_wr = 1'b0; otp_busy = 1'b0;
        check("R9 err blocked by otp", err, 1);
        look(base(1'b1, 3)); check("R9 mapping kept under otp", part_idx, 1);
    endtask

    task automatic t_op_req;
        write_cfg(3'b100);              // {0,1,2} and {3}
        @(negedge clk);
        pe_busy = 1'b1; busy_addr = base(1'b1, 0);
        addr = base(1'b1, 2); op_req = 1'b1;
        @(negedge clk);
        op_req = 1'b0;
        check("R10 same partition rejected", err, 1);
        @(negedge clk);
        check("R10 err one cycle", err, 0);
        addr = base(1'b1, 3); op_req = 1'b1;
        @(negedge clk);
        op_req = 1'b0;
        check("R10 other partition accepted", err, 0);
        pe_busy = 1'b0;
    endtask

    task automatic t_exclusive;
        write_cfg(3'b111);
        @(negedge clk);
        chip_erase_busy = 1'b1;
        for (int p = 0; p < 4; p++) begin
            look(base(1'b1, p));
            check("R7 chip erase status", rd_status, 1);
        end
        chip_erase_busy = 1'b0; otp_busy = 1'b1;
        look(base(1'b1, 1)); check("R7 otp status", rd_status, 1);
        op_req = 1'b1;
        @(negedge clk);
        op_req = 1'b0;
        check("R11 request during otp", err, 1);
        otp_busy = 1'b0;
        @(negedge clk);
        check("R11 err clears", err, 0);
    endtask

    initial begin
        t_reset;
        t_plane;
        t_cfg_all;
        t_dual;
        t_cfg_blocked;
        t_op_req;
        t_exclusive;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule